// File: doc/BRIEF.md
# Byte-Lane DMA Channel Controller

This block is one channel of a byte-wide direct memory access engine. It copies bytes between a 24-bit memory-side address, the A side, and a small peripheral window, the B side. The B-side address for each byte is built from the window base 0x2100, a programmable port byte and a small offset that follows a repeating per-mode pattern. The memory-side address can count up, count down or stay fixed. Its bank byte never changes. The channel counts the bytes down, charges a cycle cost for each byte against a budget, and clears its enable flag when it stops.

Software programs seven byte-wide registers and then pulses `start`. While the channel runs it issues one bus access at a time over a req/ack handshake, with a read phase and then a write phase for each normal byte. An outside address decoder watches `a_cursor` and drives `a_is_wram` when that address falls in internal work RAM. When the port byte is 0x80 and the flag is set, the transfer is replaced by a cheaper special case.

The sequencer has six named states:
- ST_IDLE waits for `start`.
- ST_CHECK classifies the byte and goes to ST_READ for a normal byte. For a special byte it goes to ST_WRITE on the B-to-A path or to ST_STEP on the A-to-B path.
- ST_READ waits for ack and then goes to ST_WRITE.
- ST_WRITE waits for ack and then goes to ST_STEP.
- ST_STEP updates the address, count and cycle total, then goes back to ST_CHECK or on to ST_DONE.
- ST_DONE pulses `done` and returns to ST_IDLE.

Top module: `dma_lane_channel`

## Requirements
- R1: The register offsets are 0 control, 1 port, 2/3/4 A address low/mid/bank, and 5/6 count low/high. All seven read back what was written. Offset 7 raises `reg_bad` during the access, stores nothing, and leaves every register unchanged.
- R2: The control byte layout is bit 7 direction (1 = B-to-A), bit 4 step-down, bit 3 hold, and bits 2:0 mode. Bits 6:5 have no effect.
- R3: The B address for byte i is {8'h00, (16'h2100 | port) + off(i)}. The offset off(i) follows the mode: 1 gives 0,1 repeating; 3 gives 0,0,1,1 repeating; 4 gives 0,1,2,3 repeating; every other mode gives 0.
- R4: In A-to-B, each byte reads the A address and writes the read data to the B address. In B-to-A, each byte reads the B address and writes the read data to the A address.
- R5: With hold set, the A address stays fixed. Otherwise its low 16 bits step by -1 (step-down set) or +1 after each byte and wrap around. The bank byte never changes.
- R6: The count decrements once per byte. The run always moves at least one byte and stops when the count reaches zero, so a count of 0 moves 65536 bytes.
- R7: The cycle total starts at 8 and adds each byte's cost (8 normally). The run stops after the first byte that brings the total to the budget or above. `done_cycles` shows the final total.
- R8: When the port is 0x80 and `a_is_wram` is high: in A-to-B the byte makes no bus access and costs 8; in B-to-A the byte is a single write of 0xFF to the A address and costs 4.
- R9: `enable` rises on an accepted start. `done` pulses for one cycle at the end of the run, and `enable` is low from the following cycle.
- R10: While the channel is busy, register writes and start pulses are ignored.
- R11: `m_req` is low while idle. Once raised, it stays high with a stable address, direction and write data until `m_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| reg_bad | output | 1 | Access to an unmapped offset |
| start | input | 1 | Begin a run |
| cycle_budget | input | 20 | Cycle budget for the run |
| enable | output | 1 | Channel enable flag |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_cycles | output | 20 | Cycle total of the last run |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Access is a write |
| m_addr | output | 24 | Bus access address |
| m_wdata | output | 8 | Bus write data |
| m_ack | input | 1 | Access completed |
| m_rdata | input | 8 | Read data, valid with m_ack |
| a_is_wram | input | 1 | Current A address maps to work RAM |
| a_cursor | output | 24 | Current A address |

## Verification
Runs in modes 0, 1, 2, 3, 4 and 6 with differing byte counts show whether the B-offset pattern repeats with the right period and whether unused modes fall back to offset 0. Both directions, all three A-stepping choices, and a start address just below a 64 KiB boundary separate errors in data flow, step sign and bank protection. A port of 0x80 is run with the flag high in each direction and with the flag low, which separates the special cases from a plain transfer. A small budget with a large count, and a count of zero on the cheap no-access path, check the two ways a run can end.

// File: rtl/dma_lane_pkg.sv
package dma_lane_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int CYC_W  = 20;
    localparam int NREG   = 7;
    localparam int REG_AW = 3;

    localparam int OFF_CTRL  = 0;
    localparam int OFF_PORT  = 1;
    localparam int OFF_A_LO  = 2;
    localparam int OFF_A_MID = 3;
    localparam int OFF_A_BNK = 4;
    localparam int OFF_N_LO  = 5;
    localparam int OFF_N_HI  = 6;

    localparam logic [15:0] B_WINDOW  = 16'h2100;
    localparam logic [7:0]  WRAM_PORT = 8'h80;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;

    localparam logic [CYC_W-1:0] CYC_START = CYC_W'(8);
    localparam logic [CYC_W-1:0] COST_FULL = CYC_W'(8);
    localparam logic [CYC_W-1:0] COST_WIPE = CYC_W'(4);

    typedef struct packed {
        logic       b_to_a;
        logic [1:0] spare;
        logic       step_down;
        logic       hold;
        logic [2:0] mode;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/dma_lane_regs.sv
module dma_lane_regs
    import dma_lane_pkg::*;
#(
    parameter int NR = NREG,
    parameter int AW = REG_AW,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          lock,
    input  logic          upd_en,
    input  logic [15:0]   upd_a_lo,
    input  logic [CW-1:0] upd_cnt,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_bad,
    output ctrl_t         ctrl,
    output logic [DW-1:0] port,
    output logic [23:0]   a_addr,
    output logic [CW-1:0] count
);
    logic [NR-1:0][DW-1:0] bytes_q;
    logic [NR-1:0][DW-1:0] upd_val;
    logic [NR-1:0]         upd_mask;

    always_comb begin
        upd_val  = bytes_q;
        upd_mask = '0;
        upd_val[OFF_A_LO]  = upd_a_lo[7:0];
        upd_val[OFF_A_MID] = upd_a_lo[15:8];
        upd_val[OFF_N_LO]  = upd_cnt[7:0];
        upd_val[OFF_N_HI]  = upd_cnt[15:8];
        upd_mask[OFF_A_LO]  = 1'b1;
        upd_mask[OFF_A_MID] = 1'b1;
        upd_mask[OFF_N_LO]  = 1'b1;
        upd_mask[OFF_N_HI]  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bytes_q <= '0;
        end else begin
            for (int i = 0; i < NR; i++) begin
                if (upd_en && upd_mask[i])
                    bytes_q[i] <= upd_val[i];
                else if (!lock && reg_wr && reg_addr == AW'(i))
                    bytes_q[i] <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NR; i++) begin
            if (reg_addr == AW'(i))
                reg_rdata = bytes_q[i];
        end
    end

    assign reg_bad = (reg_wr || reg_rd) && (reg_addr >= AW'(NR));
    assign ctrl    = ctrl_t'(bytes_q[OFF_CTRL]);
    assign port    = bytes_q[OFF_PORT];
    assign a_addr  = {bytes_q[OFF_A_BNK], bytes_q[OFF_A_MID], bytes_q[OFF_A_LO]};
    assign count   = {bytes_q[OFF_N_HI], bytes_q[OFF_N_LO]};
endmodule

// File: rtl/dma_lane_boffset.sv
module dma_lane_boffset #(
    parameter int MW = 3,
    parameter int IW = 2
) (
    input  logic [MW-1:0] mode,
    input  logic [IW-1:0] idx,
    output logic [1:0]    off
);
    always_comb begin
        unique case (mode)
            MW'(1):  off = {1'b0, idx[0]};
            MW'(3):  off = {1'b0, idx[1]};
            MW'(4):  off = idx[1:0];
            default: off = 2'd0;
        endcase
    end
endmodule

// File: rtl/dma_lane_seq.sv
module dma_lane_seq
    import dma_lane_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int YW = CYC_W,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] port,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    input  logic [CW-1:0] count,
    input  logic [YW-1:0] budget,
    input  logic          a_is_wram,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata,
    output logic [IW-1:0] idx,
    output logic          upd_en,
    output logic [15:0]   upd_a_lo,
    output logic [CW-1:0] upd_cnt,
    output logic          busy,
    output logic          enable,
    output logic          done,
    output logic [YW-1:0] done_cycles,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata
);
    seq_state_t    state_q, state_d;
    logic [YW-1:0] cycles_q, cost_q, cyc_next;
    logic [IW-1:0] idx_q;
    logic [DW-1:0] data_q;
    logic          wipe_q, enable_q, special, keep_going;

    assign special    = (port == WRAM_PORT) && a_is_wram;
    assign cyc_next   = cycles_q + cost_q;
    assign upd_cnt    = count - CW'(1);
    assign keep_going = (upd_cnt != '0) && (cyc_next < budget);
    assign upd_a_lo   = ctrl.hold      ? a_addr[15:0] :
                        ctrl.step_down ? a_addr[15:0] - 16'd1 :
                                         a_addr[15:0] + 16'd1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!special)          state_d = ST_READ;
                else if (ctrl.b_to_a)  state_d = ST_WRITE;
                else                   state_d = ST_STEP;
            end
            ST_READ:  if (m_ack) state_d = ST_WRITE;
            ST_WRITE: if (m_ack) state_d = ST_STEP;
            ST_STEP:  state_d = keep_going ? ST_CHECK : ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // per-run datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cycles_q <= '0;
            cost_q   <= COST_FULL;
            idx_q    <= '0;
            data_q   <= '0;
            wipe_q   <= 1'b0;
            enable_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cycles_q <= CYC_START;
                    idx_q    <= '0;
                    enable_q <= 1'b1;
                end
                ST_CHECK: begin
                    wipe_q <= special && ctrl.b_to_a;
                    cost_q <= (special && ctrl.b_to_a) ? COST_WIPE : COST_FULL;
                end
                ST_READ:  if (m_ack) data_q <= m_rdata;
                ST_WRITE: ;
                ST_STEP: begin
                    cycles_q <= cyc_next;
                    idx_q    <= idx_q + IW'(1);
                end
                ST_DONE:  enable_q <= 1'b0;
                default:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        m_wdata = '0;
        upd_en  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK: ;
            ST_READ: begin
                m_req  = 1'b1;
                m_addr = ctrl.b_to_a ? b_addr : a_addr;
            end
            ST_WRITE: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = ctrl.b_to_a ? a_addr : b_addr;
                m_wdata = wipe_q ? FILL_BYTE : data_q;
            end
            ST_STEP:  upd_en = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
    end

    assign busy        = (state_q != ST_IDLE);
    assign enable      = enable_q;
    assign done_cycles = cycles_q;
    assign idx         = idx_q;
endmodule

// File: rtl/dma_lane_channel.sv
module dma_lane_channel
    import dma_lane_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int CW  = CNT_W,
    parameter int YW  = CYC_W,
    parameter int RAW = REG_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           reg_bad,
    input  logic           start,
    input  logic [YW-1:0]  cycle_budget,
    output logic           enable,
    output logic           busy,
    output logic           done,
    output logic [YW-1:0]  done_cycles,
    output logic           m_req,
    output logic           m_we,
    output logic [AW-1:0]  m_addr,
    output logic [DW-1:0]  m_wdata,
    input  logic           m_ack,
    input  logic [DW-1:0]  m_rdata,
    input  logic           a_is_wram,
    output logic [AW-1:0]  a_cursor
);
    localparam int IW = 2;

    ctrl_t          ctrl;
    logic [DW-1:0]  port;
    logic [23:0]    a_addr;
    logic [CW-1:0]  count, upd_cnt;
    logic [15:0]    upd_a_lo;
    logic           upd_en;
    logic [IW-1:0]  idx;
    logic [1:0]     b_off;
    logic [AW-1:0]  b_addr;

    dma_lane_regs #(.NR(NREG), .AW(RAW), .DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .lock(busy), .upd_en(upd_en), .upd_a_lo(upd_a_lo), .upd_cnt(upd_cnt),
        .reg_rdata(reg_rdata), .reg_bad(reg_bad),
        .ctrl(ctrl), .port(port), .a_addr(a_addr), .count(count)
    );

    dma_lane_boffset #(.MW(3), .IW(IW)) u_boff (
        .mode(ctrl.mode), .idx(idx), .off(b_off)
    );

    assign b_addr   = AW'((B_WINDOW | {8'h00, port}) + {14'd0, b_off});
    assign a_cursor = AW'(a_addr);

    dma_lane_seq #(.AW(AW), .DW(DW), .CW(CW), .YW(YW), .IW(IW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ctrl(ctrl), .port(port), .a_addr(AW'(a_addr)), .b_addr(b_addr),
        .count(count), .budget(cycle_budget), .a_is_wram(a_is_wram),
        .m_ack(m_ack), .m_rdata(m_rdata),
        .idx(idx), .upd_en(upd_en), .upd_a_lo(upd_a_lo), .upd_cnt(upd_cnt),
        .busy(busy), .enable(enable), .done(done), .done_cycles(done_cycles),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata)
    );
endmodule

// File: rtl/dma_lane_checker.sv
module dma_lane_checker #(
    parameter int AW = 24,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          enable,
    input logic          done,
    input logic          m_req,
    input logic          m_ack,
    input logic          m_we,
    input logic [AW-1:0] m_addr,
    input logic [DW-1:0] m_wdata,
    input logic [AW-1:0] a_cursor
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata))); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req); // R11
    AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(a_cursor[AW-1:AW-8]))); // R5
    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!enable && !done)); // R9
    AST_EN_DURING_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> enable); // R9
endmodule

bind dma_lane_channel dma_lane_checker #(.AW(24), .DW(8)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .enable(enable), .done(done),
    .m_req(m_req), .m_ack(m_ack), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .a_cursor(a_cursor)
);

// File: tb/sim_dma_lane_channel.sv
module sim_dma_lane_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_bad;
    logic        start = 1'b0;
    logic [19:0] cycle_budget = '1;
    logic        enable, busy, done;
    logic [19:0] done_cycles;
    logic        m_req, m_we;
    logic [23:0] m_addr;
    logic [7:0]  m_wdata;
    logic        m_ack = 1'b0;
    logic [7:0]  m_rdata = '0;
    logic        a_is_wram;
    logic [23:0] a_cursor;

    int n_checks = 0;
    int n_fails  = 0;
    logic [32:0] exp_q [$];   // {we, addr, data}

    always #4 clk = ~clk;

    dma_lane_channel u0 (.*);

    assign a_is_wram = (a_cursor[23:16] == 8'h7E) || (a_cursor[23:16] == 8'h7F);

    function automatic logic [7:0] mem_val(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [1:0] exp_off(input logic [2:0] mode, input int i);
        case (mode)
            3'd1:    return 2'(i % 2);
            3'd3:    return ((i & 3) > 1) ? 2'd1 : 2'd0;
            3'd4:    return 2'(i & 3);
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    // monitor: answers each bus request and compares it with the queue
    initial begin
        forever begin
            @(negedge clk);
            if (m_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected access", {7'd0, m_we, m_addr}, 32'h0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    chk(m_we == e[32] && m_addr == e[31:8], "R3/R4 access address",
                        {7'd0, m_we, m_addr}, {7'd0, e[32:8]});
                    if (e[32]) chk(m_wdata == e[7:0], "R4/R8 write data", 32'(m_wdata), 32'(e[7:0]));
                end
                m_rdata = mem_val(m_addr);
                m_ack = 1'b1;
                @(negedge clk);
                m_ack = 1'b0;
            end
        end
    end

    // driver: programs a run, predicts it, starts it and checks the outcome
    task automatic do_run(input logic [7:0] ctl, input logic [7:0] prt, input logic [23:0] a0,
                          input logic [15:0] n0, input logic [19:0] bud, input bit poke, input string tag);
        logic [23:0] ai = a0;
        logic [15:0] c = n0;
        logic [19:0] cyc = 20'd8;
        int i = 0;
        logic [23:0] b;
        logic [19:0] cost;
        logic [7:0]  v;
        bit wr;
        reg_write(3'd0, ctl);  reg_write(3'd1, prt);
        reg_write(3'd2, a0[7:0]); reg_write(3'd3, a0[15:8]); reg_write(3'd4, a0[23:16]);
        reg_write(3'd5, n0[7:0]); reg_write(3'd6, n0[15:8]);
        cycle_budget = bud;
        do begin
            wr = (ai[23:16] == 8'h7E) || (ai[23:16] == 8'h7F);
            b = {8'h00, (16'h2100 | {8'h00, prt}) + {14'd0, exp_off(ctl[2:0], i)}};
            cost = 20'd8;
            if (prt == 8'h80 && wr) begin
                if (ctl[7]) begin
                    exp_q.push_back({1'b1, ai, 8'hFF});
                    cost = 20'd4;
                end
            end else if (!ctl[7]) begin
                exp_q.push_back({1'b0, ai, 8'h00});
                exp_q.push_back({1'b1, b, mem_val(ai)});
            end else begin
                exp_q.push_back({1'b0, b, 8'h00});
                exp_q.push_back({1'b1, ai, mem_val(b)});
            end
            cyc += cost;
            if (!ctl[3]) ai[15:0] = ctl[4] ? ai[15:0] - 16'd1 : ai[15:0] + 16'd1;
            c = c - 16'd1;
            i++;
        end while (c != 16'd0 && cyc < bud);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(enable == 1'b1, {"R9 enable set ", tag}, 32'(enable), 32'd1);
        if (poke) begin
            repeat (2) @(negedge clk);
            reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h33; start = 1'b1;
            @(negedge clk);
            reg_wr = 1'b0; start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(done_cycles == cyc, {"R7 cycle total ", tag}, 32'(done_cycles), 32'(cyc));
        @(negedge clk);
        chk(!enable && !busy && !done, {"R9 end state ", tag}, {29'd0, enable, busy, done}, 32'd0);
        chk(exp_q.size() == 0, {"R4 missing accesses ", tag}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
        reg_read(3'd2, v); chk(v == ai[7:0],   {"R5 A low ", tag},  32'(v), 32'(ai[7:0]));
        reg_read(3'd3, v); chk(v == ai[15:8],  {"R5 A mid ", tag},  32'(v), 32'(ai[15:8]));
        reg_read(3'd4, v); chk(v == ai[23:16], {"R5 A bank ", tag}, 32'(v), 32'(ai[23:16]));
        reg_read(3'd5, v); chk(v == c[7:0],    {"R6 count low ", tag},  32'(v), 32'(c[7:0]));
        reg_read(3'd6, v); chk(v == c[15:8],   {"R6 count high ", tag}, 32'(v), 32'(c[15:8]));
        if (poke) begin
            reg_read(3'd1, v); chk(v == prt, {"R10 port kept ", tag}, 32'(v), 32'(prt));
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'd0, 32'd1);
        finish_up();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] pat [7];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!enable && !busy && !done && !m_req, "R1 reset outputs", {28'd0, enable, busy, done, m_req}, 32'd0);
        for (int k = 0; k < 7; k++) begin
            reg_read(3'(k), v);
            chk(v == 8'h00, "R1 reset register", 32'(v), 32'd0);
        end
        // R1 write/read all offsets
        for (int k = 0; k < 7; k++) begin
            pat[k] = 8'(8'h11 * (k + 3));
            reg_write(3'(k), pat[k]);
        end
        for (int k = 0; k < 7; k++) begin
            reg_read(3'(k), v);
            chk(v == pat[k], "R1 readback", 32'(v), 32'(pat[k]));
        end
        // R1 invalid offset
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd7; reg_wdata = 8'hA5;
        #1 chk(reg_bad == 1'b1, "R1 bad offset flag", 32'(reg_bad), 32'd1);
        @(negedge clk);
        reg_wr = 1'b0;
        for (int k = 0; k < 7; k++) begin
            reg_read(3'(k), v);
            chk(v == pat[k], "R1 bad write ignored", 32'(v), 32'(pat[k]));
        end
        reg_read(3'd0, v);
        chk(reg_bad == 1'b0, "R1 valid offset flag", 32'(reg_bad), 32'd0);

        // R3/R4/R5 runs, control byte per R2 (spare bits 6:5 set in some)
        do_run(8'h00, 8'h18, 24'h01FFFE, 16'd3, 20'hFFFFF, 1'b0, "m0 a2b inc wrap");
        do_run(8'h91, 8'h22, 24'h020001, 16'd4, 20'hFFFFF, 1'b0, "m1 b2a dec");
        do_run(8'h6B, 8'h40, 24'h031234, 16'd6, 20'hFFFFF, 1'b0, "m3 a2b hold");
        do_run(8'h84, 8'h10, 24'h04FFFD, 16'd5, 20'hFFFFF, 1'b0, "m4 b2a inc");
        do_run(8'h02, 8'h05, 24'h050010, 16'd2, 20'hFFFFF, 1'b0, "m2 a2b");
        do_run(8'h16, 8'h07, 24'h060000, 16'd3, 20'hFFFFF, 1'b0, "m6 a2b dec");
        // R7 budget stops after 4 bytes
        do_run(8'h00, 8'h30, 24'h070100, 16'd10, 20'd40, 1'b0, "budget");
        // R8 special cases
        do_run(8'h80, 8'h80, 24'h7F0010, 16'd3, 20'hFFFFF, 1'b0, "wram b2a");
        do_run(8'h81, 8'h80, 24'h010020, 16'd3, 20'hFFFFF, 1'b0, "port80 plain");
        // R10 writes and start ignored while busy
        do_run(8'h04, 8'h12, 24'h080000, 16'd3, 20'hFFFFF, 1'b1, "busy poke");
        // R6/R8 count 0 moves 65536 bytes without access
        do_run(8'h00, 8'h80, 24'h7E0000, 16'd0, 20'hFFFFF, 1'b0, "wram a2b 64k");
        finish_up();
    end
endmodule